// File: doc/BRIEF.md
# Precise Exception Controller for an In-Order Pipeline

This block is the exception-control slice of a five-stage in-order pipeline. Each cycle it looks at two fault sources: an undefined-opcode flag from the decode stage and an arithmetic-overflow flag from the execute stage. Each flag comes with a valid bit and the PC of the instruction that raised it. When at least one live fault is present, the controller picks the one that is oldest in program order. In the same cycle it asserts per-stage flush signals for that instruction and every younger one. An execute-stage overflow also gets a write-kill, so its destination register is never updated. Older instructions further down the pipe are left alone and complete.

On the next clock edge the controller stores two values. The exception PC register receives the faulting PC plus one instruction width. The one-bit cause register receives 0 for an undefined opcode and 1 for an overflow. In the following cycle the controller drives a single-cycle redirect to fetch. The target is either one fixed handler entry or a per-cause vector, chosen by a configuration input. A return strobe schedules a redirect to the saved PC minus one instruction width, so the faulting instruction is fetched again and executed from scratch.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is asserted, and with idle inputs after reset, every flush output, the write-kill and the redirect output are 0, and the exception PC and cause both read 0.
- R2: A live overflow (execute valid and overflow both 1, no redirect this cycle) drives the execute, decode and fetch flushes and the write-kill to 1 in the same cycle.
- R3: A live undefined opcode with no live overflow drives the decode and fetch flushes to 1 in the same cycle and leaves the execute flush and the write-kill at 0, so the older execute instruction completes.
- R4: When both sources fault in the same cycle, the execute-stage instruction wins: the cause becomes 1 and the exception PC becomes the execute PC plus 4.
- R5: From the cycle after an accepted fault, the exception PC reads the faulting PC plus 4 and the cause reads 0 for an undefined opcode or 1 for an overflow.
- R6: The redirect output rises exactly one cycle after an accepted fault or return and stays high for one cycle only. During that cycle the fetch flush is 1 and the decode and execute flushes are 0.
- R7: With the vector-mode input at 0, a fault redirect targets 0x80000180.
- R8: With the vector-mode input at 1, a fault redirect targets 0xC0000000 plus 0x20 times the cause (0xC0000000 for undefined opcode, 0xC0000020 for overflow).
- R9: A return strobe accepted outside a redirect cycle gives a redirect in the next cycle to the exception PC minus 4 and leaves the exception PC and cause unchanged.
- R10: A fault flag whose valid bit is 0 is ignored: it causes no flush, no write-kill and no change to the exception PC or cause.
- R11: Fault requests and return strobes that arrive in a redirect cycle are ignored: they cause no decode or execute flush, no write-kill, no change to the exception PC or cause, and no redirect in the following cycle.
- R12: A fault and a return strobe in the same cycle resolve to the fault: the following redirect goes to the handler address, not the return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_mode_i | input | 1 | 1 selects per-cause handler vectors, 0 selects the single fixed entry |
| id_valid_i | input | 1 | Decode stage holds a real (non-bubble) instruction |
| id_undef_i | input | 1 | Decode stage instruction has an undefined opcode |
| id_pc_i | input | 32 | PC of the decode stage instruction |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_ovf_i | input | 1 | Execute stage instruction overflowed |
| ex_pc_i | input | 32 | PC of the execute stage instruction |
| eret_i | input | 1 | Exception-return strobe |
| flush_if_o | output | 1 | Discard the fetch stage instruction |
| flush_id_o | output | 1 | Discard the decode stage instruction |
| flush_ex_o | output | 1 | Discard the execute stage instruction |
| ex_wr_kill_o | output | 1 | Suppress the execute stage register write |
| redirect_o | output | 1 | Load the fetch PC from redirect_pc_o |
| redirect_pc_o | output | 32 | Handler or return address |
| epc_o | output | 32 | Saved exception PC (faulting PC + 4) |
| cause_o | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
The bound assertions check, on every cycle, the per-cycle relations. They cover the flush and write-kill pattern for each fault combination, the single-cycle redirect pulse and its quiet flush pattern, the capture of PC plus 4 and the cause one cycle after a fault, the fixed handler address, and the return target. Other properties depend on history that a single cycle cannot show, and only the bench scenarios can demonstrate them. One is that a return or fault arriving in a redirect cycle leaves the saved state untouched. Another is how the vector address follows a cause that was recorded several cycles earlier. A third is that a simultaneous fault and return resolve to the handler. The bench compares every output against a reference model under long random mixes of faults, bubbles and returns.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_EXC  = 2'd1,
    RK_ERET = 2'd2
  } redir_kind_e;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  typedef struct packed {
    logic fe;
    logic de;
    logic ex;
  } flush_t;
endpackage

// File: rtl/exc_prio.sv
// Oldest-first fixed priority: index 0 is the oldest stage.
module exc_prio #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] req_i,
  input  logic            block_i,
  output logic [NSRC-1:0] grant_o,
  output logic            take_o
);
  logic [NSRC:0] older_req;
  assign older_req[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign grant_o[i]     = req_i[i] & ~block_i & ~older_req[i];
    assign older_req[i+1] = older_req[i] | req_i[i];
  end

  assign take_o = |grant_o;
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int unsigned         XLEN   = 32,
  parameter int unsigned         NSRC   = 2,
  parameter logic [XLEN-1:0]     ILEN_B = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSRC-1:0]            grant_i,
  input  logic [NSRC-1:0][XLEN-1:0]  src_pc_i,
  input  cause_e [NSRC-1:0]          src_cause_i,
  input  logic                       eret_acc_i,
  output logic [XLEN-1:0]            epc_o,
  output cause_e                     cause_o,
  output redir_kind_e                kind_o
);
  logic [XLEN-1:0] sel_pc;
  logic            sel_cause;
  logic            take;

  // one-hot AND-OR select
  always_comb begin
    sel_pc    = '0;
    sel_cause = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      sel_pc    = sel_pc    | ({XLEN{grant_i[i]}} & src_pc_i[i]);
      sel_cause = sel_cause | (grant_i[i] & logic'(src_cause_i[i]));
    end
  end

  assign take = |grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= CAUSE_UNDEF;
      kind_o  <= RK_NONE;
    end else begin
      if (take) begin
        epc_o   <= sel_pc + ILEN_B;
        cause_o <= cause_e'(sel_cause);
        kind_o  <= RK_EXC;
      end else if (eret_acc_i) begin
        kind_o  <= RK_ERET;
      end else begin
        kind_o  <= RK_NONE;
      end
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] ILEN_B    = 4,
  parameter logic [XLEN-1:0] FIX_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE  = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP  = 32'h0000_0020
) (
  input  logic            vec_mode_i,
  input  redir_kind_e     kind_i,
  input  cause_e          cause_i,
  input  logic [XLEN-1:0] epc_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] vec_pc;
  logic [XLEN-1:0] exc_pc;

  assign vec_pc = VEC_BASE + (XLEN'(cause_i) * VEC_STEP);
  assign exc_pc = vec_mode_i ? vec_pc : FIX_ENTRY;

  always_comb begin
    unique case (kind_i)
      RK_ERET: pc_o = epc_i - ILEN_B;
      RK_EXC:  pc_o = exc_pc;
      default: pc_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] ILEN_B    = 4,
  parameter logic [XLEN-1:0] FIX_ENTRY = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE  = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP  = 32'h0000_0020
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vec_mode_i,
  input  logic            id_valid_i,
  input  logic            id_undef_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic            ex_valid_i,
  input  logic            ex_ovf_i,
  input  logic [XLEN-1:0] ex_pc_i,
  input  logic            eret_i,
  output logic            flush_if_o,
  output logic            flush_id_o,
  output logic            flush_ex_o,
  output logic            ex_wr_kill_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [XLEN-1:0] epc_o,
  output logic            cause_o
);
  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_EX = 0;  // oldest
  localparam int unsigned SRC_ID = 1;

  logic [NSRC-1:0]           req;
  logic [NSRC-1:0]           grant;
  logic [NSRC-1:0][XLEN-1:0] src_pc;
  cause_e [NSRC-1:0]         src_cause;
  logic                      take;
  logic                      busy;
  logic                      eret_acc;
  redir_kind_e               kind;
  cause_e                    cause_q;
  flush_t                    flush;

  assign req[SRC_EX]       = ex_valid_i & ex_ovf_i;
  assign req[SRC_ID]       = id_valid_i & id_undef_i;
  assign src_pc[SRC_EX]    = ex_pc_i;
  assign src_pc[SRC_ID]    = id_pc_i;
  assign src_cause[SRC_EX] = CAUSE_OVF;
  assign src_cause[SRC_ID] = CAUSE_UNDEF;

  assign busy     = (kind != RK_NONE);
  assign eret_acc = eret_i & ~busy & ~take;

  exc_prio #(.NSRC(NSRC)) u_prio (
    .req_i   (req),
    .block_i (busy),
    .grant_o (grant),
    .take_o  (take)
  );

  exc_state #(.XLEN(XLEN), .NSRC(NSRC), .ILEN_B(ILEN_B)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .src_pc_i    (src_pc),
    .src_cause_i (src_cause),
    .eret_acc_i  (eret_acc),
    .epc_o       (epc_o),
    .cause_o     (cause_q),
    .kind_o      (kind)
  );

  exc_target #(
    .XLEN(XLEN), .ILEN_B(ILEN_B), .FIX_ENTRY(FIX_ENTRY),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_target (
    .vec_mode_i (vec_mode_i),
    .kind_i     (kind),
    .cause_i    (cause_q),
    .epc_i      (epc_o),
    .pc_o       (redirect_pc_o)
  );

  // Faulting stage and every younger stage are flushed; during a redirect
  // only the sequentially fetched slot is dropped.
  always_comb begin
    flush.ex = grant[SRC_EX];
    flush.de = take;
    flush.fe = take | busy;
  end

  assign flush_if_o   = flush.fe;
  assign flush_id_o   = flush.de;
  assign flush_ex_o   = flush.ex;
  assign ex_wr_kill_o = grant[SRC_EX];
  assign redirect_o   = busy;
  assign cause_o      = logic'(cause_q);
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] FIX_ENTRY = 32'h8000_0180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            vec_mode_i,
  input logic            id_valid_i,
  input logic            id_undef_i,
  input logic [XLEN-1:0] id_pc_i,
  input logic            ex_valid_i,
  input logic            ex_ovf_i,
  input logic [XLEN-1:0] ex_pc_i,
  input logic            eret_i,
  input logic            flush_if_o,
  input logic            flush_id_o,
  input logic            flush_ex_o,
  input logic            ex_wr_kill_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic            cause_o
);
  logic live_ovf, live_undef;
  assign live_ovf   = ex_valid_i & ex_ovf_i;
  assign live_undef = id_valid_i & id_undef_i;

  // R2
  ovf_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_ovf && !redirect_o) |-> (flush_ex_o && flush_id_o && flush_if_o && ex_wr_kill_o));

  // R3
  undef_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_undef && !live_ovf && !redirect_o) |->
      (flush_id_o && flush_if_o && !flush_ex_o && !ex_wr_kill_o));

  // R4
  ovf_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_ovf && !redirect_o) |=> (epc_o == $past(ex_pc_i) + 32'd4 && cause_o));

  // R5
  undef_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_undef && !live_ovf && !redirect_o) |=> (epc_o == $past(id_pc_i) + 32'd4 && !cause_o));

  // R6
  redirect_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  // R6
  redirect_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_id_o && !redirect_o) |=> redirect_o);

  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (flush_if_o && !flush_id_o && !flush_ex_o && !ex_wr_kill_o));

  // R7
  fixed_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !vec_mode_i && $past(flush_id_o)) |-> (redirect_pc_o == FIX_ENTRY));

  // R9
  eret_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !redirect_o && !flush_id_o) |=>
      (redirect_o && redirect_pc_o == epc_o - 32'd4 && $stable(epc_o)));

  // R10
  bubble_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!live_ovf && !live_undef) |-> (!flush_id_o && !flush_ex_o && !ex_wr_kill_o));
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (.*);

// File: tb/tb_exc_ctrl.sv
`timescale 1ns/1ps
module tb_exc_ctrl;
  localparam logic [31:0] FIX  = 32'h8000_0180;
  localparam logic [31:0] VB   = 32'hC000_0000;
  localparam logic [31:0] VS   = 32'h0000_0020;
  localparam int          WDOG = 150000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic vec_mode_i = 0, id_valid_i = 0, id_undef_i = 0, ex_valid_i = 0, ex_ovf_i = 0, eret_i = 0;
  logic [31:0] id_pc_i = '0, ex_pc_i = '0;
  logic flush_if_o, flush_id_o, flush_ex_o, ex_wr_kill_o, redirect_o, cause_o;
  logic [31:0] redirect_pc_o, epc_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: kind 0 none, 1 exception, 2 return
  int          m_kind  = 0;
  logic [31:0] m_epc   = '0;
  logic        m_cause = 1'b0;

  always #4 clk_i = ~clk_i;

  exc_ctrl dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(int kind, logic vm, logic cause, logic [31:0] epc);
    if (kind == 2) return epc - 32'd4;
    if (kind == 1) return vm ? VB + (cause ? VS : 32'd0) : FIX;
    return 32'd0;
  endfunction

  task automatic step(logic vm, logic idv, logic idu, logic [31:0] idpc,
                      logic exv, logic exo, logic [31:0] expc, logic er, string tag);
    logic busy, exf, idf;
    string tf, tr, ts;
    @(negedge clk_i);
    vec_mode_i = vm; id_valid_i = idv; id_undef_i = idu; id_pc_i = idpc;
    ex_valid_i = exv; ex_ovf_i = exo; ex_pc_i = expc; eret_i = er;
    #1;
    busy = (m_kind != 0);
    exf  = !busy && exv && exo;
    idf  = !busy && idv && idu;
    tf = busy ? "R11" : exf ? "R2" : idf ? "R3" : "R10";
    tr = !busy ? "R6" : (m_kind == 2) ? "R9" : vm ? "R8" : "R7";
    ts = "R5";
    if (tag != "") begin tf = tag; tr = tag; ts = tag; end
    chk(tf, "flush_ex", 32'(flush_ex_o), 32'(exf));
    chk(tf, "flush_id", 32'(flush_id_o), 32'(exf | idf));
    chk(tf, "flush_if", 32'(flush_if_o), 32'(exf | idf | busy));
    chk(tf, "wr_kill", 32'(ex_wr_kill_o), 32'(exf));
    chk(tr, "redirect", 32'(redirect_o), 32'(busy));
    if (busy) chk(tr, "redirect_pc", redirect_pc_o, exp_target(m_kind, vm, m_cause, m_epc));
    chk(ts, "epc", epc_o, m_epc);
    chk(ts, "cause", 32'(cause_o), 32'(m_cause));
    // next state
    if (exf) begin m_epc = expc + 32'd4; m_cause = 1'b1; m_kind = 1; end
    else if (idf) begin m_epc = idpc + 32'd4; m_cause = 1'b0; m_kind = 1; end
    else if (!busy && er) m_kind = 2;
    else m_kind = 0;
  endtask

  task automatic idle(string tag);
    step(vec_mode_i, 0, 0, 32'h0, 0, 0, 32'h0, 0, tag);
  endtask

  initial begin
    #(WDOG * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20240613);
    // R1 reset state
    #3;
    chk("R1", "redirect in reset", 32'(redirect_o), 0);
    chk("R1", "flush_if in reset", 32'(flush_if_o), 0);
    chk("R1", "epc in reset", epc_o, 0);
    chk("R1", "cause in reset", 32'(cause_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R1");

    // R4 simultaneous faults: execute is older
    step(0, 1, 1, 32'h0000_1004, 1, 1, 32'h0000_1000, 0, "R4");
    idle("R4");
    // R8 vectored, overflow then undefined
    step(1, 0, 0, 32'h0, 1, 1, 32'h0000_2000, 0, "");
    idle("R8");
    step(1, 1, 1, 32'h0000_3000, 0, 1, 32'h0, 0, "");
    idle("R8");
    // R9 return to saved pc - 4
    step(0, 0, 0, 32'h0, 0, 0, 32'h0, 1, "R9");
    idle("R9");
    // R12 fault and return together
    step(0, 1, 1, 32'h0000_4000, 0, 0, 32'h0, 1, "R12");
    idle("R12");
    // R11 fault and return during redirect cycle
    step(0, 1, 1, 32'h0000_5000, 0, 0, 32'h0, 0, "");
    step(0, 1, 1, 32'h0000_6000, 1, 1, 32'h0000_6004, 1, "R11");
    idle("R11");
    // R10 flags without valid
    step(0, 0, 1, 32'h0000_7000, 0, 1, 32'h0000_7004, 0, "R10");
    idle("R10");

    for (int i = 0; i < 4000; i++) begin
      logic vm, idv, idu, exv, exo, er;
      vm  = ($urandom_range(0, 3) == 0);
      idv = ($urandom_range(0, 3) != 0);
      idu = ($urandom_range(0, 4) == 0);
      exv = ($urandom_range(0, 3) != 0);
      exo = ($urandom_range(0, 5) == 0);
      er  = ($urandom_range(0, 7) == 0);
      step(vm, idv, idu, {$urandom() >> 2, 2'b00}, exv, exo, {$urandom() >> 2, 2'b00}, er, "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule